// File: doc/BRIEF.md
# Ethernet MAC Pause and Back-Pressure Manager

This block decides when a small Ethernet MAC must tell its link partner to stop or resume sending, and when the MAC itself must hold back. A host programs one control/status byte. Two command bits in that byte ask for a single pause frame, one carrying pause time 0xFFFF (stop) and one carrying 0x0000 (resume). Each command bit clears itself once the transmit path reports that frame as sent. An automatic mode derives the same stop and resume frames from the receive-buffer fill level. It uses a high and a low watermark, with hysteresis between them.

In half duplex, two back-pressure modes raise a one-cycle jam request when a frame starts while the buffer is above a back-pressure watermark. One mode jams for every frame. The other jams only when the frame's destination address matched. When the receive parser reports a pause frame from the partner, a timer loaded with its quanta counts down on quanta ticks. While that timer runs and flow control is enabled, the transmitter is gated off. A sticky bit records that a pause frame arrived and clears when the host reads the byte.

Pause requests leave through a valid/ready offer carrying the pause time. `ptx_valid` rises with a stable `ptx_time` and stays up until `ptx_ready` is seen at a clock edge. The transmit path may hold `ptx_ready` low for any number of cycles. After the offer is taken, the block waits for a one-cycle `ptx_done` before it offers anything else.

Top module: `eth_pause_mgr`

## Requirements
- R1: After reset, `csr_rdata` is 0x00, `ptx_valid` and `jam_req` are 0, and `tx_enable` is 1.
- R2: Writing 1 to bit 5 of the byte requests one pause frame with time 0x0000. Bit 5 reads 1 until the `ptx_done` for that frame, then reads 0. Writing 0 to bit 5 does not cancel the request.
- R3: Writing 1 to bit 4 requests one pause frame with time 0xFFFF. Bit 4 reads 1 until that frame's `ptx_done`, then reads 0.
- R4: If bits 4 and 5 are both set, the 0xFFFF frame is offered first and the 0x0000 frame follows. After an offer is accepted, `ptx_valid` stays 0 until `ptx_done`.
- R5: While `ptx_valid` is 1 and `ptx_ready` is 0, `ptx_valid` stays 1 and `ptx_time` is unchanged on the next cycle.
- R6: With bit 1 (automatic mode) set, the first cycle with `rx_level` > `hi_mark` causes one 0xFFFF frame. A later cycle with `rx_level` < `lo_mark` causes one 0x0000 frame. No frame is produced while the level stays between the two marks.
- R7: With bit 2 set and `full_duplex` = 0, a cycle with `rx_sof` = 1 and `rx_level` > `bp_mark` gives `jam_req` = 1 for exactly the next cycle.
- R8: With bit 3 set (and bit 2 clear) in half duplex, the jam of R7 also requires `rx_da_match` = 1.
- R9: With `full_duplex` = 1, `jam_req` stays 0 whatever bits 2 and 3 hold.
- R10: Bit 6 becomes 1 the cycle after `rx_pause_evt`. It holds until a cycle with `csr_rd` = 1, after which it reads 0. If `rx_pause_evt` coincides with the read, the bit stays 1.
- R11: Bit 7 reads 1 while the received pause timer is nonzero. `rx_pause_evt` loads the timer with `rx_pause_quanta`. Each `quanta_tick` lowers it by one, and quanta 0 ends the pause at once.
- R12: `tx_enable` is 0 exactly when bit 0 (flow control enable) and bit 7 are both 1.
- R13: Writes to bits 6 and 7 have no effect. Bits 0 to 3 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Write strobe for the control byte |
| csr_wdata | input | 8 | Write data |
| csr_rd | input | 1 | Read strobe; clears bit 6 |
| csr_rdata | output | 8 | Current control/status byte |
| full_duplex | input | 1 | 1 when the link runs full duplex |
| rx_level | input | LVL_W | Receive buffer occupancy |
| hi_mark | input | LVL_W | Automatic-pause high watermark |
| lo_mark | input | LVL_W | Automatic-pause low watermark |
| bp_mark | input | LVL_W | Back-pressure watermark |
| rx_sof | input | 1 | Incoming frame start pulse |
| rx_da_match | input | 1 | Destination address of that frame matched |
| rx_pause_evt | input | 1 | Pause frame received pulse |
| rx_pause_quanta | input | PT_W | Pause time of the received frame |
| quanta_tick | input | 1 | One pause quantum elapsed |
| ptx_valid | output | 1 | Pause frame offer |
| ptx_ready | input | 1 | Transmit path accepts the offer |
| ptx_time | output | PT_W | Pause time of the offered frame |
| ptx_done | input | 1 | Accepted pause frame has been sent |
| jam_req | output | 1 | One-cycle half-duplex jam request |
| tx_enable | output | 1 | Transmitter allowed to send data frames |

## Verification
The hardest state to reach is a pending automatic request that sits behind a host command. A second case is a watermark crossing that lands exactly on a mark value. Both depend on the order of offers and on the exact fill level. The stimulus walks `rx_level` one step at a time up through the whole range and back down. It serves each offer with a delayed ready and a delayed done, so every crossing and every plateau between the marks is visited. A separate sweep covers every combination of duplex, mode bits, address match and level around the back-pressure mark.

// File: rtl/eth_pause_pkg.sv
package eth_pause_pkg;

  // control/status byte bit positions
  localparam int B_FC_EN    = 0;
  localparam int B_AUTO     = 1;
  localparam int B_BP_ANY   = 2;
  localparam int B_BP_MATCH = 3;
  localparam int B_XOFF     = 4;
  localparam int B_XON      = 5;
  localparam int B_RXP_STK  = 6;
  localparam int B_RXP_NOW  = 7;

  // origin of a pause request, used to retire it on completion
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_HOST_OFF,
    SRC_HOST_ON,
    SRC_AUTO_OFF,
    SRC_AUTO_ON
  } src_e;

  typedef enum logic [1:0] {
    ARB_IDLE,
    ARB_OFFER,
    ARB_WAIT
  } arb_st_e;

endpackage

// File: rtl/eth_pause_csr.sv
module eth_pause_csr
  import eth_pause_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       rd,
  input  src_e       done_src,
  input  logic       rx_pause_evt,
  input  logic       rx_paused,
  output logic [7:0] rdata,
  output logic       fc_en,
  output logic       auto_en,
  output logic       bp_any,
  output logic       bp_match,
  output logic       host_off,
  output logic       host_on
);

  localparam int NCMD = 2;

  logic [3:0]      ctrl_q;
  logic [NCMD-1:0] cmd_q;
  logic            stk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (wr) ctrl_q <= wdata[3:0];
  end

  // one-shot commands: set by writing 1, retired by completion of own frame
  for (genvar g = 0; g < NCMD; g++) begin : g_cmd
    localparam int   BIT = (g == 0) ? B_XOFF : B_XON;
    localparam src_e SRC = (g == 0) ? SRC_HOST_OFF : SRC_HOST_ON;
    always_ff @(posedge clk) begin
      if (!rst_n)                   cmd_q[g] <= 1'b0;
      else if (wr && wdata[BIT])    cmd_q[g] <= 1'b1;
      else if (done_src == SRC)     cmd_q[g] <= 1'b0;
    end
  end

  // received-pause sticky flag; a new event beats a simultaneous read
  always_ff @(posedge clk) begin
    if (!rst_n)            stk_q <= 1'b0;
    else if (rx_pause_evt) stk_q <= 1'b1;
    else if (rd)           stk_q <= 1'b0;
  end

  assign fc_en    = ctrl_q[B_FC_EN];
  assign auto_en  = ctrl_q[B_AUTO];
  assign bp_any   = ctrl_q[B_BP_ANY];
  assign bp_match = ctrl_q[B_BP_MATCH];
  assign host_off = cmd_q[0];
  assign host_on  = cmd_q[1];

  always_comb begin
    rdata            = '0;
    rdata[3:0]       = ctrl_q;
    rdata[B_XOFF]    = cmd_q[0];
    rdata[B_XON]     = cmd_q[1];
    rdata[B_RXP_STK] = stk_q;
    rdata[B_RXP_NOW] = rx_paused;
  end

endmodule

// File: rtl/eth_pause_wmark.sv
module eth_pause_wmark
  import eth_pause_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] hi_mark,
  input  logic [LVL_W-1:0] lo_mark,
  input  src_e             done_src,
  output logic             auto_off,
  output logic             auto_on
);

  logic above_q;
  logic off_q;
  logic on_q;

  wire go_high = !above_q && (level > hi_mark);
  wire go_low  =  above_q && (level < lo_mark);

  always_ff @(posedge clk) begin
    if (!rst_n || !auto_en) begin
      above_q <= 1'b0;
      off_q   <= 1'b0;
      on_q    <= 1'b0;
    end else if (go_high) begin
      above_q <= 1'b1;
      off_q   <= 1'b1;
      on_q    <= 1'b0;
    end else if (go_low) begin
      above_q <= 1'b0;
      on_q    <= 1'b1;
      off_q   <= 1'b0;
    end else begin
      if (done_src == SRC_AUTO_OFF) off_q <= 1'b0;
      if (done_src == SRC_AUTO_ON)  on_q  <= 1'b0;
    end
  end

  assign auto_off = off_q;
  assign auto_on  = on_q;

endmodule

// File: rtl/eth_pause_arb.sv
module eth_pause_arb
  import eth_pause_pkg::*;
#(
  parameter int              PT_W      = 16,
  parameter logic [PT_W-1:0] XOFF_TIME = '1,
  parameter logic [PT_W-1:0] XON_TIME  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_off,
  input  logic            host_on,
  input  logic            auto_off,
  input  logic            auto_on,
  output logic            ptx_valid,
  input  logic            ptx_ready,
  output logic [PT_W-1:0] ptx_time,
  input  logic            ptx_done,
  output src_e            done_src
);

  arb_st_e         st_q;
  src_e            srv_q;
  src_e            pick;
  logic [PT_W-1:0] time_q;

  // fixed priority: host stop, host resume, automatic stop, automatic resume
  always_comb begin
    if (host_off)      pick = SRC_HOST_OFF;
    else if (host_on)  pick = SRC_HOST_ON;
    else if (auto_off) pick = SRC_AUTO_OFF;
    else if (auto_on)  pick = SRC_AUTO_ON;
    else               pick = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ARB_IDLE;
      srv_q  <= SRC_NONE;
      time_q <= '0;
    end else begin
      case (st_q)
        ARB_IDLE: if (pick != SRC_NONE) begin
          st_q   <= ARB_OFFER;
          srv_q  <= pick;
          time_q <= (pick == SRC_HOST_OFF || pick == SRC_AUTO_OFF) ? XOFF_TIME : XON_TIME;
        end
        ARB_OFFER: if (ptx_ready) st_q <= ARB_WAIT;
        ARB_WAIT: if (ptx_done) begin
          st_q  <= ARB_IDLE;
          srv_q <= SRC_NONE;
        end
        default: st_q <= ARB_IDLE;
      endcase
    end
  end

  assign ptx_valid = (st_q == ARB_OFFER);
  assign ptx_time  = time_q;
  assign done_src  = (st_q == ARB_WAIT && ptx_done) ? srv_q : SRC_NONE;

endmodule

// File: rtl/eth_pause_rxmon.sv
module eth_pause_rxmon #(
  parameter int LVL_W = 8,
  parameter int PT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_duplex,
  input  logic             bp_any,
  input  logic             bp_match,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] bp_mark,
  input  logic             rx_sof,
  input  logic             rx_da_match,
  input  logic             rx_pause_evt,
  input  logic [PT_W-1:0]  rx_pause_quanta,
  input  logic             quanta_tick,
  output logic             rx_paused,
  output logic             jam_req
);

  logic [PT_W-1:0] tmr_q;
  logic            jam_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          tmr_q <= '0;
    else if (rx_pause_evt)               tmr_q <= rx_pause_quanta;
    else if (quanta_tick && tmr_q != '0) tmr_q <= tmr_q - 1'b1;
  end

  wire over_bp = level > bp_mark;
  wire want    = bp_any || (bp_match && rx_da_match);

  always_ff @(posedge clk) begin
    if (!rst_n) jam_q <= 1'b0;
    else        jam_q <= !full_duplex && rx_sof && over_bp && want;
  end

  assign rx_paused = (tmr_q != '0);
  assign jam_req   = jam_q;

endmodule

// File: rtl/eth_pause_mgr.sv
module eth_pause_mgr
  import eth_pause_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int PT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [7:0]       csr_wdata,
  input  logic             csr_rd,
  output logic [7:0]       csr_rdata,
  input  logic             full_duplex,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] hi_mark,
  input  logic [LVL_W-1:0] lo_mark,
  input  logic [LVL_W-1:0] bp_mark,
  input  logic             rx_sof,
  input  logic             rx_da_match,
  input  logic             rx_pause_evt,
  input  logic [PT_W-1:0]  rx_pause_quanta,
  input  logic             quanta_tick,
  output logic             ptx_valid,
  input  logic             ptx_ready,
  output logic [PT_W-1:0]  ptx_time,
  input  logic             ptx_done,
  output logic             jam_req,
  output logic             tx_enable
);

  localparam logic [PT_W-1:0] STOP_TIME   = {PT_W{1'b1}};
  localparam logic [PT_W-1:0] RESUME_TIME = {PT_W{1'b0}};

  src_e done_src;
  logic fc_en, auto_en, bp_any, bp_match;
  logic host_off, host_on, auto_off, auto_on;
  logic rx_paused;

  eth_pause_csr u_csr (
    .clk, .rst_n,
    .wr(csr_wr), .wdata(csr_wdata), .rd(csr_rd),
    .done_src, .rx_pause_evt, .rx_paused,
    .rdata(csr_rdata),
    .fc_en, .auto_en, .bp_any, .bp_match, .host_off, .host_on
  );

  eth_pause_wmark #(.LVL_W(LVL_W)) u_wmark (
    .clk, .rst_n, .auto_en,
    .level(rx_level), .hi_mark, .lo_mark,
    .done_src, .auto_off, .auto_on
  );

  eth_pause_arb #(.PT_W(PT_W), .XOFF_TIME(STOP_TIME), .XON_TIME(RESUME_TIME)) u_arb (
    .clk, .rst_n, .host_off, .host_on, .auto_off, .auto_on,
    .ptx_valid, .ptx_ready, .ptx_time, .ptx_done, .done_src
  );

  eth_pause_rxmon #(.LVL_W(LVL_W), .PT_W(PT_W)) u_rxmon (
    .clk, .rst_n, .full_duplex, .bp_any, .bp_match,
    .level(rx_level), .bp_mark, .rx_sof, .rx_da_match,
    .rx_pause_evt, .rx_pause_quanta, .quanta_tick,
    .rx_paused, .jam_req
  );

  assign tx_enable = !(fc_en && rx_paused);

endmodule

// File: rtl/eth_pause_mgr_chk.sv
module eth_pause_mgr_chk #(
  parameter int PT_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_wr,
  input logic [7:0]      csr_rdata,
  input logic            full_duplex,
  input logic            rx_pause_evt,
  input logic            ptx_valid,
  input logic            ptx_ready,
  input logic [PT_W-1:0] ptx_time,
  input logic            ptx_done,
  input logic            jam_req,
  input logic            tx_enable
);

  logic outst_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      outst_q <= 1'b0;
    else if (ptx_valid && ptx_ready) outst_q <= 1'b1;
    else if (ptx_done)               outst_q <= 1'b0;
  end

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ptx_valid && !ptx_ready |=> ptx_valid && $stable(ptx_time)); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !ptx_valid); // R4
  AST_JAM_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> !$past(full_duplex)); // R9
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[0] && csr_rdata[7] |-> !tx_enable); // R12
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_evt |=> csr_rdata[6]); // R10
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[5] && !ptx_done |=> csr_rdata[5]); // R2
  AST_STICKY_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr && !rx_pause_evt && !csr_rdata[6] |=> !csr_rdata[6]); // R13

endmodule

bind eth_pause_mgr eth_pause_mgr_chk #(.PT_W(PT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rdata(csr_rdata),
  .full_duplex(full_duplex), .rx_pause_evt(rx_pause_evt),
  .ptx_valid(ptx_valid), .ptx_ready(ptx_ready), .ptx_time(ptx_time),
  .ptx_done(ptx_done), .jam_req(jam_req), .tx_enable(tx_enable)
);

// File: tb/eth_pause_mgr_tb_top.sv
module eth_pause_mgr_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 8;
  localparam int PT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_wr = 0, csr_rd = 0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic full_duplex = 0;
  logic [LVL_W-1:0] rx_level = '0, hi_mark = '0, lo_mark = '0, bp_mark = '0;
  logic rx_sof = 0, rx_da_match = 0, rx_pause_evt = 0, quanta_tick = 0;
  logic [PT_W-1:0] rx_pause_quanta = '0;
  logic ptx_valid, ptx_ready = 0, ptx_done = 0;
  logic [PT_W-1:0] ptx_time;
  logic jam_req, tx_enable;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_pause_mgr #(.LVL_W(LVL_W), .PT_W(PT_W)) dut_i (
    .clk, .rst_n, .csr_wr, .csr_wdata, .csr_rd, .csr_rdata,
    .full_duplex, .rx_level, .hi_mark, .lo_mark, .bp_mark,
    .rx_sof, .rx_da_match, .rx_pause_evt, .rx_pause_quanta, .quanta_tick,
    .ptx_valid, .ptx_ready, .ptx_time, .ptx_done, .jam_req, .tx_enable
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_write(logic [7:0] v);
    csr_wr = 1; csr_wdata = v;
    cyc(1);
    csr_wr = 0; csr_wdata = '0;
  endtask

  // wait for an offer, check its time, stall ready, then complete it
  task automatic serve(logic [PT_W-1:0] exp_time, string req);
    int n = 0;
    while (!ptx_valid && n < 8) begin cyc(1); n++; end
    check({req, " offer"}, 32'(ptx_valid), 32'd1);
    check({req, " time"}, 32'(ptx_time), 32'(exp_time));
    cyc(2);
    check("R5 held", 32'({ptx_valid, ptx_time}), 32'({1'b1, exp_time}));
    ptx_ready = 1; cyc(1); ptx_ready = 0;
    cyc(3);
    check("R4 outstanding", 32'(ptx_valid), 32'd0);
    ptx_done = 1; cyc(1); ptx_done = 0;
  endtask

  task automatic expect_idle(string req);
    cyc(3);
    check(req, 32'(ptx_valid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1
    check("R1 rdata", 32'(csr_rdata), 32'h00);
    check("R1 valid", 32'(ptx_valid), 32'd0);
    check("R1 jam", 32'(jam_req), 32'd0);
    check("R1 txen", 32'(tx_enable), 32'd1);

    // R13: control bits read back, status bits not writable
    csr_write(8'h0F);
    check("R13 ctrl", 32'(csr_rdata), 32'h0F);
    csr_write(8'hC0);
    check("R13 status ignored", 32'(csr_rdata), 32'h00);

    // R2
    csr_write(8'h20);
    check("R2 bit set", 32'(csr_rdata[5]), 32'd1);
    csr_write(8'h00);
    check("R2 not cancelled", 32'(csr_rdata[5]), 32'd1);
    serve(16'h0000, "R2");
    check("R2 cleared", 32'(csr_rdata[5]), 32'd0);
    expect_idle("R2 single frame");

    // R3
    csr_write(8'h10);
    check("R3 bit set", 32'(csr_rdata[4]), 32'd1);
    serve(16'hFFFF, "R3");
    check("R3 cleared", 32'(csr_rdata[4]), 32'd0);
    expect_idle("R3 single frame");

    // R4
    csr_write(8'h30);
    serve(16'hFFFF, "R4 first");
    check("R4 order bits", 32'(csr_rdata[5:4]), 32'b10);
    serve(16'h0000, "R4 second");
    check("R4 both clear", 32'(csr_rdata[5:4]), 32'b00);
    expect_idle("R4 no extra");

    // R6: level sweep up and down with hysteresis model
    hi_mark = 8'd40; lo_mark = 8'd10;
    csr_write(8'h02);
    begin
      bit above = 0;
      for (int step = 0; step < 128; step++) begin
        int lvl = (step < 64) ? step : 127 - step;
        rx_level = LVL_W'(lvl);
        cyc(1);
        if (!above && lvl > 40) begin
          above = 1;
          serve(16'hFFFF, "R6 stop");
        end else if (above && lvl < 10) begin
          above = 0;
          serve(16'h0000, "R6 resume");
        end else begin
          expect_idle("R6 hysteresis");
        end
      end
    end
    csr_write(8'h00);
    rx_level = '0;

    // R7 R8 R9: back-pressure sweep
    bp_mark = 8'd20;
    for (int fd = 0; fd < 2; fd++)
      for (int mode = 0; mode < 4; mode++)
        for (int da = 0; da < 2; da++)
          for (int d = -1; d <= 1; d++) begin
            bit exp_jam;
            full_duplex = fd[0];
            csr_write(8'(mode << 2));
            rx_level = LVL_W'(20 + d);
            rx_da_match = da[0];
            exp_jam = (fd == 0) && (d > 0) && (mode[0] || (mode[1] && da == 1));
            rx_sof = 1; cyc(1); rx_sof = 0;
            check(fd ? "R9 jam" : (mode[0] ? "R7 jam" : "R8 jam"),
                  32'(jam_req), 32'(exp_jam));
            cyc(1);
            check("R7 pulse", 32'(jam_req), 32'd0);
          end
    full_duplex = 0; rx_da_match = 0; rx_level = '0;
    csr_write(8'h00);

    // R10 R11 R12
    csr_write(8'h01);
    rx_pause_quanta = 16'd3; rx_pause_evt = 1; cyc(1); rx_pause_evt = 0;
    check("R11 now", 32'(csr_rdata[7]), 32'd1);
    check("R10 sticky", 32'(csr_rdata[6]), 32'd1);
    check("R12 gated", 32'(tx_enable), 32'd0);
    for (int t = 1; t <= 3; t++) begin
      quanta_tick = 1; cyc(1); quanta_tick = 0;
      check("R11 count", 32'(csr_rdata[7]), 32'(t < 3));
      check("R12 follow", 32'(tx_enable), 32'(t >= 3));
    end
    check("R10 held", 32'(csr_rdata[6]), 32'd1);
    csr_rd = 1; cyc(1); csr_rd = 0;
    check("R10 cleared", 32'(csr_rdata[6]), 32'd0);
    rx_pause_quanta = 16'd5; rx_pause_evt = 1; cyc(1); rx_pause_evt = 0;
    rx_pause_quanta = 16'd0; rx_pause_evt = 1; csr_rd = 1; cyc(1);
    rx_pause_evt = 0; csr_rd = 0;
    check("R10 event wins", 32'(csr_rdata[6]), 32'd1);
    check("R11 zero quanta", 32'(csr_rdata[7]), 32'd0);
    csr_write(8'h00);
    rx_pause_quanta = 16'd5; rx_pause_evt = 1; cyc(1); rx_pause_evt = 0;
    check("R12 disabled", 32'({csr_rdata[7], tx_enable}), 32'b11);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule